// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block accepts a write job made of a byte start address, a byte count and a stream of source bytes, and turns it into a sequence of aligned 32-bit word writes. Before it builds each word it reads the word that is already stored at that address. Byte lanes that the job does not cover are filled from that stored word: the lanes below the start offset in the first word, and the lanes past the last source byte in the final word. The stored word is read every time, so each finished word can be checked against the current contents. A word that would need any bit to go from 0 to 1 is rejected before it is written.

The job is started by a one-cycle pulse. The source bytes arrive on a valid/ready stream. Finished words leave on a request/acknowledge write port, and the write acknowledge carries a status code. The block takes no new source byte while a word write is outstanding. The first failure ends the job, and the job reports one result code.

Top module: `byte_word_packer`

## Requirements
- R1: The first word address is the start address with its two low bits forced to zero. Each later word address is the previous one plus 4. The read of a word uses the same address as the write of that word.
- R2: Byte lane k of a word (k = 0..3) occupies bits [31-8k:24-8k], so lane 0 is the most significant byte. In the first word, lanes below the start offset (start address bits [1:0]) take their value from the stored word.
- R3: Source bytes fill the lanes in arrival order, beginning at the start offset in the first word and at lane 0 in every later word.
- R4: When the byte count runs out before lane 3, every remaining higher lane takes its value from the stored word. This applies to a tail word and to a job that both starts and ends inside one word.
- R5: While 4 or more source bytes remain at a word boundary, the block emits a word made only of source bytes. A job that ends without a failure reports result 0.
- R6: A word whose stored value ANDed with the new value differs from the new value is not written. The job ends with result 2.
- R7: A write acknowledged with a nonzero status ends the job at once, and that status becomes the result (1 means write timeout). No later words are read or written.
- R8: A job with a byte count of 0 raises done in the cycle after start, with result 0, and performs no read and no write.
- R9: in_ready is high only while a lane needs a source byte. It is low whenever a write request is pending and whenever the block is idle. The block never takes more than byte_count source bytes.
- R10: A write request keeps its address and data stable until it is acknowledged. Its address always has bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts a job; ignored while busy |
| start_addr | input | AW | Byte address of the first source byte |
| byte_count | input | CW | Number of source bytes in the job |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| result | output | 2 | Job result: 0 ok, 1 write timeout, 2 not erased |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Packer takes the source byte this cycle |
| rd_en | output | 1 | Read strobe for the stored word |
| rd_addr | output | AW | Word-aligned read address |
| rd_data | input | 32 | Stored word, valid one cycle after rd_en |
| wr_req | output | 1 | Word write request, held until acknowledged |
| wr_addr | output | AW | Word-aligned write address |
| wr_data | output | 32 | Word to write |
| wr_ack | input | 1 | Write acknowledge |
| wr_status | input | 2 | Write status returned with wr_ack; nonzero is a failure |

## Verification
If the lane counter or the start-offset register is corrupted, the wrong word shows up on wr_data at the first write request. That write comes a few cycles after the source bytes of that word have been taken. A wrong remaining-byte count shows up in two ways: the block takes the wrong number of source bytes on the stream, or it issues an extra word or too few words. Either is visible by the end of the job. A broken failure path shows up in the result field. It can also show up as a write request that appears after a rejected word or after a failed acknowledge.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  localparam int WB  = 4;          // bytes per word
  localparam int DW  = WB * 8;     // word width
  localparam int OFS = $clog2(WB); // lane index width

  localparam logic [1:0] RES_OK       = 2'd0;
  localparam logic [1:0] RES_NOT_ERAS = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_RWAIT, ST_FILL, ST_CHECK, ST_WRITE
  } pk_state_t;

  // Lane 0 is the most significant byte.
  function automatic logic [7:0] lane_of(input logic [DW-1:0] w, input logic [OFS-1:0] lane);
    return w[(WB - 1 - int'(lane)) * 8 +: 8];
  endfunction

  // A new byte enters at the low end; earlier bytes move up.
  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] w, input logic [7:0] b);
    return {w[DW-9:0], b};
  endfunction

  // True when programming new_w would need a bit to rise from 0 to 1.
  function automatic logic needs_rise(input logic [DW-1:0] stored, input logic [DW-1:0] new_w);
    return (stored & new_w) != new_w;
  endfunction
endpackage

// File: rtl/bwp_word_shift.sv
module bwp_word_shift
  import bwp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift,
  input  logic [7:0]    byte_in,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (shift) word <= shift_in(word, byte_in);
  end
endmodule

// File: rtl/bwp_erase_chk.sv
module bwp_erase_chk
  import bwp_pkg::*;
(
  input  logic [DW-1:0] stored,
  input  logic [DW-1:0] new_w,
  output logic          blocked
);
  always_comb blocked = needs_rise(stored, new_w);
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import bwp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_count,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  input  logic [1:0]    wr_status
);
  localparam logic [OFS-1:0] LAST_LANE = OFS'(WB - 1);
  localparam logic [AW-1:0]  STEP      = AW'(WB);

  pk_state_t      st;
  logic [AW-1:0]  wp;
  logic [CW-1:0]  rem;
  logic [OFS-1:0] lane, lead;
  logic [DW-1:0]  stored_w, build_w;

  // Named internal events, used by the checker.
  logic use_stored, byte_take, src_take, word_full, reject_evt, write_fire, blocked;
  logic [7:0] lane_byte;

  always_comb begin
    use_stored = (lane < lead) || (rem == '0);
    byte_take  = (st == ST_FILL) && (use_stored || in_valid);
    src_take   = byte_take && !use_stored;
    word_full  = byte_take && (lane == LAST_LANE);
    lane_byte  = use_stored ? lane_of(stored_w, lane) : in_data;
    reject_evt = (st == ST_CHECK) && blocked;
    write_fire = wr_req && wr_ack;
  end

  bwp_word_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clear(st == ST_READ), .shift(byte_take),
    .byte_in(lane_byte), .word(build_w)
  );

  bwp_erase_chk u_echk (.stored(stored_w), .new_w(build_w), .blocked(blocked));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wp       <= '0;
      rem      <= '0;
      lane     <= '0;
      lead     <= '0;
      stored_w <= '0;
      done     <= 1'b0;
      result   <= RES_OK;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          result <= RES_OK;
          if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            wp   <= {start_addr[AW-1:OFS], {OFS{1'b0}}};
            lead <= start_addr[OFS-1:0];
            rem  <= byte_count;
            st   <= ST_READ;
          end
        end
        ST_READ: begin
          lane <= '0;
          st   <= ST_RWAIT;
        end
        ST_RWAIT: begin
          stored_w <= rd_data;
          st       <= ST_FILL;
        end
        ST_FILL: if (byte_take) begin
          lane <= lane + 1'b1;
          if (src_take) rem <= rem - CW'(1);
          if (word_full) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (blocked) begin
            result <= RES_NOT_ERAS;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_WRITE;
          end
        end
        ST_WRITE: if (wr_ack) begin
          if (wr_status != RES_OK || rem == '0) begin
            result <= wr_status;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            wp   <= wp + STEP;
            lead <= '0;
            st   <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (st != ST_IDLE);
    in_ready = (st == ST_FILL) && !use_stored;
    rd_en    = (st == ST_READ);
    rd_addr  = wp;
    wr_req   = (st == ST_WRITE);
    wr_addr  = wp;
    wr_data  = build_w;
  end
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [CW-1:0] byte_count,
  input logic          done,
  input logic [1:0]    result,
  input logic          in_ready,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          wr_ack,
  input logic [1:0]    wr_status,
  input logic          reject_evt,
  input logic          write_fire
);
  // R1: reads are word aligned
  a_r1_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[1:0] == 2'b00);

  // R6: a rejected word ends the job with code 2 and never reaches the write port
  a_r6_reject_stops: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> done && result == 2'd2 && !wr_req);

  // R7: a failed acknowledge ends the job with its status
  a_r7_status_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (write_fire && wr_status != 2'd0) |=> done && result == $past(wr_status) && !busy);

  // R8: an empty job finishes in the next cycle with success
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> done && result == 2'd0 && !busy);

  // R9: no source byte is taken while a write is pending
  a_r9_stall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !in_ready);

  // R10: a pending request holds its address and data
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R10: write addresses are word aligned
  a_r10_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr[1:0] == 2'b00);
endmodule

bind byte_word_packer bwp_checker #(.AW(AW), .CW(CW)) u_bwp_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .byte_count(byte_count),
  .done(done), .result(result), .in_ready(in_ready), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
  .wr_status(wr_status), .reject_evt(reject_evt), .write_fire(write_fire)
);

// File: tb/byte_word_packer_bench.sv
module byte_word_packer_bench;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          busy, done, in_ready, rd_en, wr_req;
  logic [1:0]    result;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_data = '0;
  logic [31:0]   wr_data;
  logic          wr_ack = 1'b0;
  logic [1:0]    wr_status = '0;

  byte_word_packer #(.AW(AW), .CW(CW)) u_byte_word_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .result(result),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_status(wr_status)
  );

  logic [31:0] mem [0:63];
  logic [7:0]  src [0:63];
  logic [31:0] log_a [0:63];
  logic [31:0] log_d [0:63];
  logic [31:0] exp_a [0:15];
  logic [31:0] exp_d [0:15];
  int exp_n, exp_res, exp_used;
  int tmo_idx = 99;
  int wr_n = 0, rd_n = 0, wr_base = 0, dly = 0;
  int total = 0, bad = 0;

  // Storage model: one-cycle read latency.
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr[7:2]];
      rd_n    <= rd_n + 1;
    end
  end

  // Write responder with random acknowledge delay and an injectable timeout.
  always @(posedge clk) begin
    if (wr_req && !wr_ack) begin
      if (dly == 0) begin
        wr_ack    <= 1'b1;
        wr_status <= ((wr_n - wr_base) == tmo_idx) ? 2'd1 : 2'd0;
        log_a[wr_n % 64] <= wr_addr;
        log_d[wr_n % 64] <= wr_data;
        wr_n <= wr_n + 1;
      end else begin
        dly <= dly - 1;
      end
    end else begin
      wr_ack <= 1'b0;
      dly    <= $urandom % 3;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Reference: walks the lanes of each word from the requirement text.
  task automatic predict(input int sa, input int cnt, input int tmo);
    int wa, head, used;
    bit first, over;
    logic [31:0] w;
    logic [7:0] b;
    wa = sa - (sa % 4);
    head = sa % 4;
    used = 0;
    first = 1;
    over = (cnt == 0);
    exp_n = 0;
    exp_res = 0;
    while (!over) begin
      w = 32'h0;
      for (int ln = 0; ln < 4; ln++) begin
        if ((first && ln < head) || used >= cnt) b = mem[wa / 4][(3 - ln) * 8 +: 8];
        else begin
          b = src[used];
          used++;
        end
        w[(3 - ln) * 8 +: 8] = b;
      end
      if ((mem[wa / 4] | ~w) != 32'hFFFF_FFFF) begin
        exp_res = 2;
        over = 1;
      end else begin
        exp_a[exp_n] = wa;
        exp_d[exp_n] = w;
        exp_n++;
        if (exp_n - 1 == tmo) begin
          exp_res = 1;
          over = 1;
        end else if (used >= cnt) over = 1;
        else begin
          wa += 4;
          first = 0;
        end
      end
    end
    exp_used = used;
  endtask

  task automatic run_job(input int sa, input int cnt, input int tmo);
    int sent, guard, rd_base;
    bit pend, seen;
    predict(sa, cnt, tmo);
    tmo_idx = tmo;
    wr_base = wr_n;
    rd_base = rd_n;
    @(negedge clk);
    start = 1'b1;
    start_addr = AW'(sa);
    byte_count = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
    sent = 0;
    pend = 0;
    seen = 0;
    guard = 0;
    while (!seen && guard < 3000) begin
      if (pend) sent++;
      if (done) seen = 1;
      else begin
        in_valid = (sent < cnt) && ($urandom % 4 != 0);
        in_data  = (sent < cnt) ? src[sent] : 8'h00;
        pend = in_valid && in_ready;
        guard++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    check("watchdog: job ended", 32'(seen), 32'd1);
    if (exp_res == 2)      check("R6 result not-erased", 32'(result), 32'd2);
    else if (exp_res == 1) check("R7 result timeout", 32'(result), 32'd1);
    else                   check("R5 result ok", 32'(result), 32'd0);
    check("R6 R7 number of writes", 32'(wr_n - wr_base), 32'(exp_n));
    check("R9 source bytes taken", 32'(sent), 32'(exp_used));
    if (cnt == 0) check("R8 no reads", 32'(rd_n - rd_base), 32'd0);
    for (int i = 0; i < exp_n && i < (wr_n - wr_base); i++) begin
      check("R1 R10 write address", log_a[(wr_base + i) % 64], exp_a[i]);
      check("R2 R3 R4 R5 write data", log_d[(wr_base + i) % 64], exp_d[i]);
    end
  endtask

  task automatic erase_all();
    for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    erase_all();
    for (int i = 0; i < 64; i++) src[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset: in_ready low", 32'(in_ready), 32'd0);
    check("R10 reset: no write request", 32'(wr_req), 32'd0);
    check("R8 reset: idle, done low", 32'({busy, done, rd_en}), 32'd0);

    // R8: empty job
    run_job(10, 0, 99);
    // R5: aligned, two full words
    run_job(16, 8, 99);
    // R2 R4: head and tail merged inside one word
    mem[8] = 32'hA5C3_5A3C;
    src[0] = 8'h00; src[1] = 8'h00;
    run_job(33, 2, 99);
    // R2: only the last lane comes from the stream
    mem[12] = 32'h1122_3344;
    src[0] = 8'h00;
    run_job(51, 1, 99);
    // R3 R4: offset 2, nine bytes over three words
    erase_all();
    for (int i = 0; i < 64; i++) src[i] = 8'(i * 13 + 1);
    run_job(66, 9, 99);
    // R6: second word has programmed bits that the new data needs
    mem[21] = 32'h0F0F_0F0F;
    for (int i = 0; i < 16; i++) src[i] = 8'hFF;
    run_job(80, 12, 99);
    // R7: timeout reported on the second write
    erase_all();
    for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
    run_job(100, 12, 1);

    for (int t = 0; t < 60; t++) begin
      int cnt, sa, tmo;
      for (int i = 0; i < 64; i++) mem[i] = ($urandom % 4 == 0) ? $urandom : 32'hFFFF_FFFF;
      for (int i = 0; i < 64; i++) src[i] = ($urandom % 2 == 0) ? 8'($urandom) : 8'h00;
      cnt = $urandom % 25;
      sa  = $urandom % (216 - cnt);
      tmo = ($urandom % 6 == 0) ? int'($urandom % 3) : 99;
      run_job(sa, cnt, tmo);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule